// File: doc/BRIEF.md
# Multi-Issue Dependency Check

This block decides, every clock cycle, how many instructions at the head of an N-entry issue window may leave together. Each window entry has a valid bit, an instruction class, up to two source register operands and one destination operand. Every operand carries a register-file tag, so the integer and floating-point register sets never alias. The block checks each source against the destinations of earlier valid entries in the same window. It also checks each source against a scoreboard that holds the destinations of instructions issued in earlier cycles that have not yet completed. Each instruction class also holds a seat in one of four issue slots.

Issue is in order. The block grants the longest run of valid entries that have no hazard and no slot conflict. Invalid entries are bubbles: they are skipped, and they neither block later entries nor create dependencies. A granted instruction marks its destination busy in the scoreboard. Completion ports clear busy bits when results are written back. Both scoreboard files are visible as outputs.

Top module: `issue_gate`

## Requirements
- R1: An entry whose valid bit is 0 is never granted. It does not stop later entries, and its destination creates no dependency for them.
- R2: A source in use stalls its entry when an earlier valid entry in the same window writes the same register number with the same file tag (file tag 0 = integer, 1 = float).
- R3: Operands with the same register number but different file tags never depend on each other, either in the window or against the scoreboard.
- R4: A source in use stalls its entry while the scoreboard bit for that register and file is set.
- R5: Per cycle, at most one instruction is granted per issue slot. The slots are: integer unit (class 0, and codes 5 to 7), float unit (class 1 float op and class 4 convert), memory (class 2 load/store) and branch (class 3). An entry whose slot is already taken is withheld.
- R6: Once any valid entry is withheld, no later entry in the window is granted in that cycle.
- R7: When an entry with a destination in use is granted, its scoreboard bit reads 1 from the next clock edge on.
- R8: An enabled completion port clears the addressed scoreboard bit at the next edge. If the same bit is set by an issue in the same cycle, it stays set.
- R9: Writes to integer register 0 are never tracked. busy_int bit 0 stays 0, and reading integer register 0 never stalls.
- R10: After reset, both scoreboard files are all zero.
- R11: A convert instruction's sources and destination are each checked against the file named by their own tag. For example, an integer source is stalled by busy_int and not by busy_fp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | N | Valid bit per window entry, entry 0 oldest |
| win_class | input | 3*N | Class code per entry: 0 int, 1 float, 2 load/store, 3 branch, 4 convert |
| src_use | input | 2*N | Source-in-use flags, bit 2k+s for entry k, source s |
| src_fp | input | 2*N | Source file tags, 1 = float |
| src_reg | input | 2*N*RW | Source register numbers |
| dst_use | input | N | Destination-in-use flag per entry |
| dst_fp | input | N | Destination file tag per entry |
| dst_reg | input | N*RW | Destination register number per entry |
| done_en | input | NC | Completion port enables |
| done_fp | input | NC | Completion port file tags |
| done_reg | input | NC*RW | Completion port register numbers |
| grant | output | N | Issue grant per entry |
| busy_int | output | 2**RW | Integer scoreboard, one bit per register |
| busy_fp | output | 2**RW | Float scoreboard, one bit per register |

## Verification
The hardest case to reach from the ports is a set and a clear of the same scoreboard bit in the same cycle. Next to it is a convert whose source tag points at the file opposite to a busy register with the same number. Neither arises often by chance. A directed sequence therefore first leaves specific bits busy, then in one cycle drives a completion and a granted write to the same register. It also places converts against busy registers of either file. A long pseudo-random sweep over an eight-register configuration then compares every grant and scoreboard value with an arithmetic model kept in the bench.

// File: rtl/issue_gate.sv
module issue_gate #(
  parameter int N  = 4,
  parameter int RW = 5,
  parameter int NC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        win_valid,
  input  logic [3*N-1:0]      win_class,
  input  logic [2*N-1:0]      src_use,
  input  logic [2*N-1:0]      src_fp,
  input  logic [2*N*RW-1:0]   src_reg,
  input  logic [N-1:0]        dst_use,
  input  logic [N-1:0]        dst_fp,
  input  logic [N*RW-1:0]     dst_reg,
  input  logic [NC-1:0]       done_en,
  input  logic [NC-1:0]       done_fp,
  input  logic [NC*RW-1:0]    done_reg,
  output logic [N-1:0]        grant,
  output logic [(1<<RW)-1:0]  busy_int,
  output logic [(1<<RW)-1:0]  busy_fp
);
  localparam int NR = 1 << RW;

  logic [N-1:0] tracked;
  logic [N-1:0] hazard;
  logic [3:0]   unit [N];

  for (genvar k = 0; k < N; k++) begin : g_slot
    assign tracked[k] = win_valid[k] & dst_use[k] & (dst_fp[k] | (|dst_reg[k*RW +: RW]));

    always_comb begin
      case (win_class[3*k +: 3])
        3'd1, 3'd4: unit[k] = 4'b0010;
        3'd2:       unit[k] = 4'b0100;
        3'd3:       unit[k] = 4'b1000;
        default:    unit[k] = 4'b0001;
      endcase
    end

    always_comb begin
      logic [RW-1:0] r;
      logic          f;
      hazard[k] = 1'b0;
      for (int s = 0; s < 2; s++) begin
        r = src_reg[(2*k+s)*RW +: RW];
        f = src_fp[2*k+s];
        if (src_use[2*k+s]) begin
          if (f ? busy_fp[r] : busy_int[r]) hazard[k] = 1'b1;
          for (int j = 0; j < k; j++)
            if (tracked[j] && dst_reg[j*RW +: RW] == r && dst_fp[j] == f)
              hazard[k] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic       open;
    logic [3:0] used;
    open  = 1'b1;
    used  = 4'b0;
    grant = '0;
    for (int k = 0; k < N; k++) begin
      if (win_valid[k]) begin
        if (open && !hazard[k] && !(|(used & unit[k]))) begin
          grant[k] = 1'b1;
          used     = used | unit[k];
        end else begin
          open = 1'b0;
        end
      end
    end
  end

  logic [NR-1:0] set_i, set_f, clr_i, clr_f;

  always_comb begin
    set_i = '0;
    set_f = '0;
    clr_i = '0;
    clr_f = '0;
    for (int k = 0; k < N; k++)
      if (grant[k] && tracked[k]) begin
        if (dst_fp[k]) set_f[dst_reg[k*RW +: RW]] = 1'b1;
        else           set_i[dst_reg[k*RW +: RW]] = 1'b1;
      end
    for (int c = 0; c < NC; c++)
      if (done_en[c]) begin
        if (done_fp[c]) clr_f[done_reg[c*RW +: RW]] = 1'b1;
        else            clr_i[done_reg[c*RW +: RW]] = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_int <= '0;
      busy_fp  <= '0;
    end else begin
      busy_int <= (busy_int & ~clr_i) | set_i;
      busy_fp  <= (busy_fp  & ~clr_f) | set_f;
    end
  end
endmodule

// File: rtl/issue_gate_chk.sv
module issue_gate_chk #(
  parameter int N  = 4,
  parameter int RW = 5,
  parameter int NC = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        win_valid,
  input logic [3*N-1:0]      win_class,
  input logic [2*N-1:0]      src_use,
  input logic [2*N-1:0]      src_fp,
  input logic [2*N*RW-1:0]   src_reg,
  input logic [N-1:0]        dst_use,
  input logic [N-1:0]        dst_fp,
  input logic [N*RW-1:0]     dst_reg,
  input logic [N-1:0]        grant,
  input logic [(1<<RW)-1:0]  busy_int,
  input logic [(1<<RW)-1:0]  busy_fp
);
  logic [N-1:0] held, m_int, m_fpu, m_mem, m_br;
  assign held = win_valid & ~grant;

  always_comb begin
    m_int = '0; m_fpu = '0; m_mem = '0; m_br = '0;
    for (int k = 0; k < N; k++)
      case (win_class[3*k +: 3])
        3'd1, 3'd4: m_fpu[k] = 1'b1;
        3'd2:       m_mem[k] = 1'b1;
        3'd3:       m_br[k]  = 1'b1;
        default:    m_int[k] = 1'b1;
      endcase
  end

  // R1
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~win_valid) == '0);

  // R5
  slot_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant & m_mem) <= 1);
  // R5
  slot_fpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant & m_fpu) <= 1);
  // R5
  slot_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant & m_int) <= 1);
  // R5
  slot_br_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant & m_br) <= 1);

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_int[0] == 1'b0);

  for (genvar k = 0; k < N; k++) begin : g_k
    logic [N-1:0] lowm;
    assign lowm = (N'(1) << k) - N'(1);

    // R6
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[k] |-> (held & lowm) == '0);

    // R7
    mark_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k] && dst_use[k] && (dst_fp[k] || dst_reg[k*RW +: RW] != '0)) |=>
      ($past(dst_fp[k]) ? busy_fp[$past(dst_reg[k*RW +: RW])]
                        : busy_int[$past(dst_reg[k*RW +: RW])]));

    for (genvar s = 0; s < 2; s++) begin : g_s
      // R4
      no_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[k] && src_use[2*k+s]) |->
        !(src_fp[2*k+s] ? busy_fp[src_reg[(2*k+s)*RW +: RW]]
                        : busy_int[src_reg[(2*k+s)*RW +: RW]]));
    end
  end
endmodule

bind issue_gate issue_gate_chk #(.N(N), .RW(RW), .NC(NC)) u_chk (.*);

// File: tb/issue_gate_bench.sv
module issue_gate_bench;
  localparam int P  = 10;
  localparam int N  = 4;
  localparam int RW = 3;
  localparam int NC = 2;
  localparam int NR = 1 << RW;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] win_valid = '0, dst_use = '0, dst_fp = '0;
  logic [3*N-1:0] win_class = '0;
  logic [2*N-1:0] src_use = '0, src_fp = '0;
  logic [2*N*RW-1:0] src_reg = '0;
  logic [N*RW-1:0] dst_reg = '0;
  logic [NC-1:0] done_en = '0, done_fp = '0;
  logic [NC*RW-1:0] done_reg = '0;
  logic [N-1:0] grant;
  logic [NR-1:0] busy_int, busy_fp;

  always #(P/2) clk = ~clk;

  issue_gate #(.N(N), .RW(RW), .NC(NC)) u_issue_gate (.*);

  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic [NR-1:0] mi = '0, mf = '0;
  logic [N-1:0] eg;
  logic [31:0] lf = 32'h1234_5678;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_win();
    win_valid = '0; win_class = '0; src_use = '0; src_fp = '0; src_reg = '0;
    dst_use = '0; dst_fp = '0; dst_reg = '0; done_en = '0; done_fp = '0; done_reg = '0;
  endtask

  task automatic put(int k, int c, bit u0, int r0, bit f0, bit u1, int r1, bit f1,
                     bit du, int dr, bit df);
    win_valid[k] = 1'b1;
    win_class[3*k +: 3] = 3'(c);
    src_use[2*k] = u0; src_reg[2*k*RW +: RW] = RW'(r0); src_fp[2*k] = f0;
    src_use[2*k+1] = u1; src_reg[(2*k+1)*RW +: RW] = RW'(r1); src_fp[2*k+1] = f1;
    dst_use[k] = du; dst_reg[k*RW +: RW] = RW'(dr); dst_fp[k] = df;
  endtask

  function automatic int seat(int c);
    if (c == 1 || c == 4) return 1;
    if (c == 2) return 2;
    if (c == 3) return 3;
    return 0;
  endfunction

  function automatic logic [N-1:0] model();
    logic [N-1:0] g = '0;
    bit stop = 0;
    bit [3:0] taken = '0;
    for (int k = 0; k < N; k++) begin
      bit blocked = 0;
      if (!win_valid[k]) continue;
      for (int s = 0; s < 2; s++) begin
        int r = int'(src_reg[(2*k+s)*RW +: RW]);
        bit f = src_fp[2*k+s];
        if (!src_use[2*k+s]) continue;
        if (f && mf[r]) blocked = 1;
        if (!f && mi[r]) blocked = 1;
        for (int j = 0; j < k; j++)
          if (win_valid[j] && dst_use[j] && int'(dst_reg[j*RW +: RW]) == r &&
              dst_fp[j] == f && (f || r != 0))
            blocked = 1;
      end
      if (taken[seat(int'(win_class[3*k +: 3]))]) blocked = 1;
      if (stop || blocked) stop = 1;
      else begin
        g[k] = 1'b1;
        taken[seat(int'(win_class[3*k +: 3]))] = 1'b1;
      end
    end
    return g;
  endfunction

  task automatic step(string req, bit use_exp, logic [N-1:0] exp);
    #1;
    eg = model();
    chk("model grant", 32'(grant), 32'(eg));
    if (use_exp) chk(req, 32'(grant), 32'(exp));
    @(posedge clk);
    for (int c = 0; c < NC; c++)
      if (done_en[c]) begin
        if (done_fp[c]) mf[done_reg[c*RW +: RW]] = 1'b0;
        else            mi[done_reg[c*RW +: RW]] = 1'b0;
      end
    for (int k = 0; k < N; k++)
      if (eg[k] && dst_use[k] && (dst_fp[k] || dst_reg[k*RW +: RW] != '0)) begin
        if (dst_fp[k]) mf[dst_reg[k*RW +: RW]] = 1'b1;
        else           mi[dst_reg[k*RW +: RW]] = 1'b1;
      end
    #1;
    chk("model busy_int", 32'(busy_int), 32'(mi));
    chk("model busy_fp", 32'(busy_fp), 32'(mf));
    @(negedge clk);
    clr_win();
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(P*200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 busy_int after reset", 32'(busy_int), 0);
    chk("R10 busy_fp after reset", 32'(busy_fp), 0);
    @(negedge clk);
    rst_n = 1;
    clr_win();

    put(0, 0, 0,0,0, 0,0,0, 1,3,0); put(1, 1, 1,3,1, 0,0,0, 1,6,1);
    step("R3 int dst vs float src", 1, 4'b0011);
    chk("R7 int3 busy", 32'(busy_int), 32'h08);
    chk("R7 fp6 busy", 32'(busy_fp), 32'h40);

    done_en = 2'b11; done_reg = {3'd6, 3'd3}; done_fp = 2'b10;
    step("R8 idle", 1, 4'b0000);
    chk("R8 clear int", 32'(busy_int), 0);
    chk("R8 clear fp", 32'(busy_fp), 0);

    put(0, 0, 0,0,0, 0,0,0, 1,3,0); put(1, 2, 1,3,0, 0,0,0, 0,0,0);
    step("R2 window RAW", 1, 4'b0001);

    put(0, 4, 1,3,1, 0,0,0, 1,5,0); put(1, 2, 1,3,0, 0,0,0, 0,0,0);
    step("R11 convert fp src vs busy int3 / R4", 1, 4'b0001);
    chk("R11 convert int dst", 32'(busy_int), 32'h28);

    put(0, 4, 1,5,0, 0,0,0, 1,1,1);
    step("R11 convert int src busy", 1, 4'b0000);

    done_en = 2'b11; done_reg = {3'd3, 3'd5}; done_fp = 2'b00;
    put(0, 0, 0,0,0, 0,0,0, 1,5,0);
    step("R8 set with clear", 1, 4'b0001);
    chk("R8 set wins", 32'(busy_int), 32'h20);

    put(0, 2, 0,0,0, 0,0,0, 0,0,0); put(1, 2, 0,0,0, 0,0,0, 0,0,0);
    put(2, 3, 0,0,0, 0,0,0, 0,0,0);
    step("R5 R6 two memory ops", 1, 4'b0001);

    put(0, 1, 0,0,0, 0,0,0, 0,0,0); put(1, 4, 0,0,0, 0,0,0, 0,0,0);
    step("R5 convert shares float seat", 1, 4'b0001);

    put(0, 0, 0,0,0, 0,0,0, 0,0,0); put(1, 1, 0,0,0, 0,0,0, 0,0,0);
    put(2, 2, 0,0,0, 0,0,0, 0,0,0); put(3, 3, 0,0,0, 0,0,0, 0,0,0);
    step("R5 one per seat", 1, 4'b1111);

    put(0, 0, 0,0,0, 0,0,0, 1,2,0); win_valid[0] = 1'b0;
    put(1, 0, 1,2,0, 0,0,0, 0,0,0);
    step("R1 invalid entry", 1, 4'b0010);

    put(0, 0, 0,0,0, 0,0,0, 1,0,0); put(1, 2, 1,0,0, 0,0,0, 0,0,0);
    step("R9 int r0", 1, 4'b0011);
    chk("R9 r0 untracked", 32'(busy_int), 32'h20);

    for (int t = 0; t < 5000; t++) begin
      for (int k = 0; k < N; k++) begin
        lf = nxt(lf);
        put(k, int'(lf[2:0]), lf[3], int'(lf[6:4]), lf[7], lf[8], int'(lf[11:9]), lf[12],
            lf[13] | lf[14], int'(lf[17:15]), lf[18]);
        win_valid[k] = (lf[21:19] != 3'd0);
      end
      lf = nxt(lf);
      done_en = lf[1:0] | lf[3:2]; done_fp = lf[5:4];
      done_reg = lf[6 +: 2*RW];
      step("random", 0, '0);
    end
    finish_run();
  end
endmodule